// File: doc/BRIEF.md
# Stacked-Leg Carrier PWM Gate Generator

This block drives the gates of an inverter in which several three-phase outputs share one leg per phase. Each leg is a column of OUTS+1 series switches. One symmetric triangular carrier serves every phase. Each modulating word is compared with that carrier, and adjacent comparison results are combined into switch commands. When the words of a leg are held in strictly falling order, exactly OUTS of its OUTS+1 switches conduct. Each command then passes through a dead-time stage, which holds back every turn-on while turn-offs go through at once.

Modulating words arrive as one frame on a valid/ready stream, carrying OUTS signed words for each phase. The block raises `in_ready` only in the cycle where the carrier sits at its peak or valley, so the words cannot change part way through a slope. Upstream must hold `in_valid` and `in_words` steady until it sees a cycle with both high. Until then the previous words stay in use. A frame whose words are out of order in any phase sets a sticky fault, and the fault turns every gate off until reset.

Top module: `stkpwm_gate`

## Requirements
- R1: The carrier is a signed count that resets to -CAR_MAX and then rises by one per clock to +CAR_MAX. It then falls by one per clock back to -CAR_MAX and repeats, with a period of 4*CAR_MAX clocks.
- R2: `in_ready` is high exactly in the cycles where the carrier equals +CAR_MAX or -CAR_MAX. A frame is taken only on a clock edge with `in_valid` and `in_ready` both high, and it is in use from the next cycle. At any other edge the held words and the fault flag are unchanged, even if `in_valid` is high.
- R3: Word k of phase p is `in_words[(p*OUTS+k)*W +: W]`, two's complement, with k=0 the top output. Gate bit p*(OUTS+1)+j drives switch j of phase p, with j=0 the top switch. The top switch command is high when word 0 is greater than or equal to the carrier.
- R4: A middle switch j (0<j<OUTS) is commanded on when word j-1 is below the carrier or word j is at or above it.
- R5: The comparisons use the full signed word range. A word at or above +CAR_MAX keeps its comparison true all period, and a word below -CAR_MAX keeps it false all period.
- R6: The bottom switch command is high when word OUTS-1 is below the carrier.
- R7: A gate goes high one clock after its command has been high for `dead_cycles`+1 consecutive cycles. It goes low one clock after its command falls.
- R8: If the words are in order or still at their reset value, each leg has exactly OUTS commands high. Each leg never has more than OUTS gates high.
- R9: If a taken frame has any phase where word k is not strictly greater than word k+1, `fault` rises in the next cycle. It then stays high until reset, and all gates read 0 while it is high.
- R10: During and right after reset, all gates and `fault` are 0 and `in_ready` is 1. The held words reset to the most negative value, so only the switches below the top one are commanded on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dead_cycles | input | DT_W | Turn-on delay in clocks, plus one fixed clock |
| in_valid | input | 1 | Frame of modulating words is offered |
| in_ready | output | 1 | Carrier at a turning point; frame can be taken |
| in_words | input | PHASES*OUTS*W | Signed modulating words, packed by phase then output |
| gate | output | PHASES*(OUTS+1) | Gate commands after dead time and fault masking |
| fault | output | 1 | Sticky ordering violation flag |

## Verification
Two events can fall on the same clock edge. A frame is taken at a carrier turning point, and on that same edge a comparison can flip, because a word equal to +CAR_MAX or -CAR_MAX meets the carrier exactly there. Also on that same edge, an out-of-order frame makes new words and the fault flag take effect together. The bench provokes both by offering frames with words at the carrier limits, and by offering a frame with two equal words in one phase. It judges them with a per-cycle model built from the requirements. In that model the new words apply from the cycle after the edge, and in the same cycle every gate reads zero if the frame was out of order. The dead-time window counts across a word reload without a restart.

// File: rtl/stkpwm_pkg.sv
package stkpwm_pkg;
  // Direction of the shared triangular carrier.
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } car_dir_e;
endpackage

// File: rtl/stkpwm_carrier.sv
module stkpwm_carrier #(
  parameter int W       = 8,
  parameter int CAR_MAX = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic signed [W-1:0] car,
  output logic                at_turn
);
  import stkpwm_pkg::*;

  localparam logic signed [W-1:0] PEAK   = W'(CAR_MAX);
  localparam logic signed [W-1:0] VALLEY = -PEAK;
  localparam logic signed [W-1:0] ONE    = W'(1);

  car_dir_e dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car <= VALLEY;
      dir <= DIR_UP;
    end else if (dir == DIR_UP) begin
      car <= car + ONE;
      if (car == PEAK - ONE) dir <= DIR_DOWN;
    end else begin
      car <= car - ONE;
      if (car == VALLEY + ONE) dir <= DIR_UP;
    end
  end

  assign at_turn = (car == PEAK) || (car == VALLEY);
endmodule

// File: rtl/stkpwm_leg.sv
module stkpwm_leg #(
  parameter int W    = 8,
  parameter int OUTS = 3
) (
  input  logic [OUTS*W-1:0]   words,
  input  logic signed [W-1:0] car,
  output logic [OUTS:0]       cmd
);
  logic [OUTS-1:0] ge;

  for (genvar k = 0; k < OUTS; k++) begin : g_cmp
    assign ge[k] = $signed(words[k*W +: W]) >= car;
  end

  assign cmd[0]    = ge[0];
  assign cmd[OUTS] = ~ge[OUTS-1];
  for (genvar j = 1; j < OUTS; j++) begin : g_mid
    assign cmd[j] = ~ge[j-1] | ge[j];
  end
endmodule

// File: rtl/stkpwm_order.sv
module stkpwm_order #(
  parameter int W    = 8,
  parameter int OUTS = 3
) (
  input  logic [OUTS*W-1:0] words,
  output logic              ordered
);
  logic [OUTS-2:0] step_ok;

  for (genvar k = 1; k < OUTS; k++) begin : g_step
    assign step_ok[k-1] = $signed(words[(k-1)*W +: W]) > $signed(words[k*W +: W]);
  end

  assign ordered = &step_ok;
endmodule

// File: rtl/stkpwm_deadtime.sv
module stkpwm_deadtime #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd,
  input  logic [DT_W-1:0] dead,
  output logic            gate
);
  logic [DT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate <= 1'b0;
      cnt  <= '0;
    end else if (!cmd) begin
      gate <= 1'b0;
      cnt  <= '0;
    end else if (!gate) begin
      if (cnt >= dead) gate <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/stkpwm_gate.sv
module stkpwm_gate #(
  parameter int PHASES  = 3,
  parameter int OUTS    = 3,
  parameter int W       = 8,
  parameter int CAR_MAX = 100,
  parameter int DT_W    = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DT_W-1:0]             dead_cycles,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [PHASES*OUTS*W-1:0]    in_words,
  output logic [PHASES*(OUTS+1)-1:0]  gate,
  output logic                        fault
);
  localparam int SW      = OUTS + 1;
  localparam int GATES   = PHASES * SW;
  localparam int LEG_W   = OUTS * W;
  localparam int WORDS_W = PHASES * LEG_W;
  localparam logic [W-1:0] MIN_WORD = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] car_q;
  logic                at_turn;
  logic [WORDS_W-1:0]  word_q;
  logic [GATES-1:0]    raw_cmd;
  logic [GATES-1:0]    dt_gate;
  logic [PHASES-1:0]   ordered;
  logic                fault_q;
  logic                accept;

  stkpwm_carrier #(.W(W), .CAR_MAX(CAR_MAX)) u_car (
    .clk(clk), .rst_n(rst_n), .car(car_q), .at_turn(at_turn)
  );

  assign in_ready = at_turn;
  assign accept   = in_valid & at_turn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= {(PHASES*OUTS){MIN_WORD}};
      fault_q <= 1'b0;
    end else if (accept) begin
      word_q  <= in_words;
      fault_q <= fault_q | ~(&ordered);
    end
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    stkpwm_order #(.W(W), .OUTS(OUTS)) u_ord (
      .words(in_words[p*LEG_W +: LEG_W]), .ordered(ordered[p])
    );
    stkpwm_leg #(.W(W), .OUTS(OUTS)) u_leg (
      .words(word_q[p*LEG_W +: LEG_W]), .car(car_q), .cmd(raw_cmd[p*SW +: SW])
    );
    for (genvar j = 0; j < SW; j++) begin : g_sw
      stkpwm_deadtime #(.DT_W(DT_W)) u_dt (
        .clk(clk), .rst_n(rst_n), .cmd(raw_cmd[p*SW+j]),
        .dead(dead_cycles), .gate(dt_gate[p*SW+j])
      );
    end
  end

  assign gate  = fault_q ? '0 : dt_gate;
  assign fault = fault_q;
endmodule

// File: rtl/stkpwm_gate_chk.sv
module stkpwm_gate_chk #(
  parameter int PHASES  = 3,
  parameter int OUTS    = 3,
  parameter int W       = 8,
  parameter int CAR_MAX = 100,
  parameter int DT_W    = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic signed [W-1:0]        car,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [PHASES*OUTS*W-1:0]   word_q,
  input logic [PHASES*(OUTS+1)-1:0] raw_cmd,
  input logic [PHASES*(OUTS+1)-1:0] gate,
  input logic                       fault
);
  localparam int SW = OUTS + 1;
  localparam logic signed [W-1:0] PEAK = W'(CAR_MAX);
  localparam logic signed [W-1:0] ONE  = W'(1);

  // R1: carrier moves by exactly one step per clock
  a_r1_car_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (car == $past(car) + ONE) || (car == $past(car) - ONE));

  // R1: carrier stays within its signed span
  a_r1_car_span: assert property (@(posedge clk) disable iff (!rst_n)
    (car <= PEAK) && (car >= -PEAK));

  // R2: held words change only on an accepted frame
  a_r2_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(word_q));

  // R9: fault is sticky and masks every gate
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  a_r9_safe: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (gate == '0));

  for (genvar p = 0; p < PHASES; p++) begin : g_leg
    // R8: ordered words give exactly OUTS commands per leg
    a_r8_three_cmds: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |-> ($countones(raw_cmd[p*SW +: SW]) == OUTS));
    // R8: never more than OUTS gates on per leg
    a_r8_gate_cap: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gate[p*SW +: SW]) <= OUTS);
  end

  for (genvar s = 0; s < PHASES*SW; s++) begin : g_sw
    // R7: a gate never turns on without its command held beforehand
    a_r7_rise_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate[s]) |-> $past(raw_cmd[s]));
  end
endmodule

bind stkpwm_gate stkpwm_gate_chk #(
  .PHASES(PHASES), .OUTS(OUTS), .W(W), .CAR_MAX(CAR_MAX), .DT_W(DT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .car(car_q), .in_valid(in_valid),
  .in_ready(in_ready), .word_q(word_q), .raw_cmd(raw_cmd),
  .gate(gate), .fault(fault)
);

// File: tb/test_stkpwm_gate.sv
module test_stkpwm_gate;
  localparam int CLK_PERIOD = 10;
  localparam int PH  = 3;
  localparam int OU  = 3;
  localparam int W   = 8;
  localparam int CM  = 100;
  localparam int DTW = 6;
  localparam int SW  = OU + 1;
  localparam int G   = PH * SW;
  localparam int WW  = PH * OU * W;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [DTW-1:0] dead_cycles = '0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [WW-1:0]  in_words = '0;
  logic [G-1:0]   gate;
  logic           fault;

  int checks = 0;
  int errors = 0;

  stkpwm_gate #(.PHASES(PH), .OUTS(OU), .W(W), .CAR_MAX(CM), .DT_W(DTW)) i_stkpwm_gate (
    .clk(clk), .rst_n(rst_n), .dead_cycles(dead_cycles), .in_valid(in_valid),
    .in_ready(in_ready), .in_words(in_words), .gate(gate), .fault(fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [WW-1:0] pk(input int v [9]);
    logic [WW-1:0] r;
    for (int i = 0; i < 9; i++) r[i*W +: W] = v[i][W-1:0];
    return r;
  endfunction

  function automatic int wd(input logic [WW-1:0] w, input int p, input int k);
    return int'($signed(w[(p*OU+k)*W +: W]));
  endfunction

  function automatic bit in_order(input logic [WW-1:0] w);
    for (int p = 0; p < PH; p++)
      for (int k = 0; k < OU-1; k++)
        if (!(wd(w, p, k) > wd(w, p, k+1))) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int car_of(input int n);
    int ph;
    ph = n % (4*CM);
    return (ph <= 2*CM) ? (-CM + ph) : (3*CM - ph);
  endfunction

  // Scoreboard state
  logic [WW-1:0] wq [$];
  logic [WW-1:0] words_m;
  logic [G-1:0]  hist [64];
  bit            fault_m;
  int            n;

  always @(negedge clk) begin
    if (!rst_n) begin
      n = 0;
      fault_m = 1'b0;
      for (int i = 0; i < PH*OU; i++) words_m[i*W +: W] = {1'b1, {(W-1){1'b0}}};
      for (int i = 0; i < 64; i++) hist[i] = '0;
    end else begin
      int c;
      int d;
      logic [G-1:0] exp_g;
      logic [G-1:0] raw;
      c = car_of(n);
      d = int'(dead_cycles);
      // R1 R2: ready only at carrier turning points
      chk(in_ready == ((c == CM) || (c == -CM)), "R1 R2 ready", 64'(in_ready), 64'((c == CM) || (c == -CM)));
      // R7 dead-time window over command history, R9 masking
      for (int s = 0; s < G; s++) begin
        bit e;
        e = (n >= d + 1);
        for (int j = 0; j <= d; j++)
          if (n - 1 - j >= 0) e = e & hist[(n-1-j) % 64][s];
        exp_g[s] = fault_m ? 1'b0 : e;
      end
      chk(gate == exp_g, fault_m ? "R9 gates" : (d > 0 ? "R7 gates" : "R3 R4 R5 R6 gates"), 64'(gate), 64'(exp_g));
      chk(fault == fault_m, "R9 fault", 64'(fault), 64'(fault_m));
      // R3 R4 R6 command model from the current words and carrier
      for (int p = 0; p < PH; p++) begin
        raw[p*SW] = wd(words_m, p, 0) >= c;
        for (int j = 1; j < OU; j++)
          raw[p*SW+j] = !(wd(words_m, p, j-1) >= c) || (wd(words_m, p, j) >= c);
        raw[p*SW+OU] = !(wd(words_m, p, OU-1) >= c);
        // R8: gate count per leg
        if (d == 0 && n >= 1 && !fault_m)
          chk($countones(gate[p*SW +: SW]) == OU, "R8 count", 64'($countones(gate[p*SW +: SW])), 64'(OU));
      end
      hist[n % 64] = raw;
      if (in_valid && in_ready) begin
        if (wq.size() == 0) begin
          chk(1'b0, "R2 unexpected accept", 64'(in_words), 64'(0));
        end else begin
          logic [WW-1:0] w;
          w = wq.pop_front();
          words_m = w;
          if (!in_order(w)) fault_m = 1'b1;
        end
      end
      n++;
    end
  end

  task automatic do_reset(input int d);
    @(posedge clk); #1;
    rst_n = 1'b0;
    in_valid = 1'b0;
    dead_cycles = DTW'(d);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: outputs during reset
    chk(gate == '0, "R10 gate in reset", 64'(gate), 64'(0));
    chk(fault == 1'b0, "R10 fault in reset", 64'(fault), 64'(0));
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready after reset", 64'(in_ready), 64'(1));
  endtask

  task automatic load(input logic [WW-1:0] w);
    @(posedge clk); #1;
    wq.push_back(w);
    in_words = w;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic junk(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      in_valid = !in_ready;
      in_words = pk('{-50, 90, 90, 7, 7, 7, -1, 100, -100});
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [WW-1:0] wa, wb, wc, wbad, wbad2;
    wa    = pk('{60, 10, -40, 30, 0, -90, 95, 50, -5});
    wb    = pk('{127, 0, -128, 100, -100, -101, -20, -60, -99});
    wc    = pk('{5, 4, 3, -1, -2, -3, 99, 98, 97});
    wbad  = pk('{60, 10, -40, 30, 30, -90, 95, 50, -5});
    wbad2 = pk('{60, 10, -40, 30, 0, -90, 10, -5, 20});

    do_reset(0);
    repeat (50) @(posedge clk);
    load(wa);
    repeat (450) @(posedge clk);
    load(wb);   // R5: words at and beyond the carrier limits
    repeat (450) @(posedge clk);
    junk(150);  // R2: offered frames off the turning points are ignored
    @(negedge clk);
    chk(fault == 1'b0, "R2 junk ignored", 64'(fault), 64'(0));
    load(wc);
    repeat (420) @(posedge clk);

    do_reset(3);  // R7
    load(wa);
    repeat (820) @(posedge clk);

    do_reset(7);  // R7
    load(wb);
    repeat (420) @(posedge clk);

    do_reset(2);  // R9: equal words in one phase
    load(wa);
    repeat (220) @(posedge clk);
    load(wbad);
    @(negedge clk);
    chk(fault == 1'b1, "R9 fault raised", 64'(fault), 64'(1));
    load(wa);
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(fault == 1'b1 && gate == '0, "R9 sticky safe", 64'({fault, gate}), 64'({1'b1, 12'h0}));

    do_reset(0);  // R9: reversed pair in the last phase
    load(wbad2);
    repeat (200) @(posedge clk);
    @(negedge clk);
    chk(fault == 1'b1, "R9 fault reversed", 64'(fault), 64'(1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule